// File: doc/BRIEF.md
# Smart Card UART Status Register

This block builds the 8-bit status byte of a smart card UART and the transmit-empty interrupt request. It gathers pulses from the receiver (overrun, parity, missing stop bit, silent byte), per-entry error tags as bytes enter and leave the receive FIFO, and transmit-side events, and shows them all on one byte that the host reads.

The receive-FIFO error bit is driven by a count of the errored entries that are still queued. A host read clears that bit only when the count has reached zero, so an error cannot be acknowledged while a bad byte is still waiting to be drained. The transmit-buffer-empty bit has two meanings. With the FIFO disabled, it marks the hand-off of a byte from the holding register to the shift register. With the FIFO enabled, it marks the transmit FIFO running dry. When this bit is set and the interrupt enable is high, the block raises an interrupt request.

Top module: `sc_status_reg`

## Requirements
- R1: After reset the status byte reads 8'h60 (with `tx_sr_empty`=1 and `rx_ready`=0) and `irq` is 0.
- R2: Status bit 0 equals `rx_ready` in the same cycle, with no register in the path.
- R3: Bits 1..4 (overrun, parity, no-stop, silent byte, from bit 1 up) are set by a pulse on the matching event input. They then hold until a cycle with `status_rd`=1, after which they read 0. An event in the same cycle as the read leaves its bit set.
- R4: Status bit 7 becomes 1 in the cycle after a push tagged with an error (`fifo_push`=1, `fifo_push_err`=1).
- R5: A read clears bit 7 only if the count of errored entries, after that cycle's push and pop, is zero. Otherwise bit 7 stays 1.
- R6: Popping the last errored entry without a read does not clear bit 7.
- R7: Status bit 6 equals `tx_sr_empty` in the same cycle.
- R8: With `fifo_mode`=0, bit 5 is set in the cycle after a `tx_hold_load` pulse. A 0-to-1 change of `tx_fifo_empty` has no effect on it.
- R9: With `fifo_mode`=1, bit 5 is set in the cycle after `tx_fifo_empty` goes from 0 to 1. `tx_hold_load` has no effect on it.
- R10: A `host_wr_tx` pulse clears bit 5 in the next cycle, even when a set event happens in the same cycle. Bit 5 is 1 after reset.
- R11: A bit 5 set event while `tbe_ie`=1 raises `irq` in the next cycle. With `tbe_ie`=0 no `irq` is raised.
- R12: `irq` drops in the cycle after bit 5 clears or after `tbe_ie` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_ready | input | 1 | Received data available |
| rx_overrun | input | 1 | Overrun event pulse |
| rx_parity_err | input | 1 | Parity error event pulse |
| rx_nostop_err | input | 1 | Missing stop bit event pulse |
| rx_silent | input | 1 | Silent byte detected pulse |
| fifo_push | input | 1 | Byte written into receive FIFO |
| fifo_push_err | input | 1 | Pushed byte carries an error |
| fifo_pop | input | 1 | Byte read out of receive FIFO |
| fifo_pop_err | input | 1 | Popped byte carried an error |
| fifo_mode | input | 1 | 1 = transmit FIFO mode |
| tx_hold_load | input | 1 | Holding register moved a byte to the shift register |
| tx_fifo_empty | input | 1 | Transmit FIFO empty level |
| tx_sr_empty | input | 1 | Transmit shift register empty level |
| host_wr_tx | input | 1 | Host writes a transmit byte |
| tbe_ie | input | 1 | Transmit-empty interrupt enable |
| status_rd | input | 1 | Host reads the status byte |
| status | output | 8 | Status byte |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
The bench drains errored and clean bytes in an interleaved order and checks that a read in the middle leaves bit 7 set. A design that cleared on any read would drop the bit early, and one that tracked only a single flag would lose the second error. It lines up an event with a read, and a set with a host write, in the same cycle. This catches priority inversions that would lose an error or leave a stale buffer-empty indication. It drives the transmit-side set sources in the wrong mode, where a design with mixed-up modes would set bit 5 spuriously, and it drops the enable while a request is pending, where a design would leave `irq` stuck high.

// File: rtl/scsr_pkg.sv
// Package: shared definitions for the smart card status register.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package scsr_pkg;
    localparam int STATUS_W = 8;
    localparam int N_RX_EVT = 4;

    // Receiver event group, LSB = overrun (lands on status bit 1).
    typedef struct packed {
        logic silent;
        logic nostop;
        logic parity;
        logic overrun;
    } rx_evt_t;
endpackage

// File: rtl/scsr_sticky_flags.sv
// Module: bank of sticky event flags cleared by a host read.
// Assumes: a set and a read in the same cycle keep the flag set.
module scsr_sticky_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         rd,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic q;
        // Hold one event bit until the host reads it.
        always_ff @(posedge clk) begin
            if (!rst_n)      q <= 1'b0;
            else if (evt[i]) q <= 1'b1;
            else if (rd)     q <= 1'b0;
        end
        assign flags[i] = q;

        // R3
        sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(evt[i] && rst_n) |-> q);
    end
endmodule

// File: rtl/scsr_rx_err_track.sv
// Module: counts errored entries in the receive FIFO and keeps the
// summary error flag with its conditional read-clear.
// Assumes the FIFO never pops an errored entry it does not hold and
// never holds more than DEPTH entries.
module scsr_rx_err_track #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_err,
    input  logic pop,
    input  logic pop_err,
    input  logic rd,
    output logic flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             inc, dec, flag_q;

    assign inc = push && push_err;
    assign dec = pop && pop_err;

    // Next errored-entry count from this cycle's push and pop.
    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec)      cnt_d = cnt_q + CNT_W'(1);
        else if (dec && !inc) cnt_d = cnt_q - CNT_W'(1);
    end

    // Register the errored-entry count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Summary flag: set on errored push, read-clear only once drained.
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (inc)                  flag_q <= 1'b1;
        else if (rd && cnt_d == '0)    flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R5
    err_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> flag_q);
    // R4
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inc && rst_n) |-> flag_q);
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |-> (cnt_q != '0));
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |-> (cnt_q < CNT_W'(DEPTH)));
endmodule

// File: rtl/scsr_tx_empty.sv
// Module: transmit-buffer-empty bit and its interrupt request.
// Assumes tx_fifo_empty is a level; its 0-to-1 change is the FIFO-mode
// set source, while tx_hold_load is a one-cycle pulse for non-FIFO mode.
module scsr_tx_empty (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode,
    input  logic hold_load,
    input  logic tx_fifo_empty,
    input  logic host_wr,
    input  logic ie,
    output logic tbre,
    output logic irq
);
    logic empty_prev_q, tbre_q, irq_q;
    logic set_evt, tbre_d;

    // Select the set source for the active mode.
    always_comb begin
        if (fifo_mode) set_evt = tx_fifo_empty && !empty_prev_q;
        else           set_evt = hold_load;
        if (host_wr)      tbre_d = 1'b0;
        else if (set_evt) tbre_d = 1'b1;
        else              tbre_d = tbre_q;
    end

    // Track the FIFO-empty level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) empty_prev_q <= 1'b1;
        else        empty_prev_q <= tx_fifo_empty;
    end

    // Buffer-empty bit, host write has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) tbre_q <= 1'b1;
        else        tbre_q <= tbre_d;
    end

    // Interrupt request: raised by an enabled set, dropped by clear or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ie && tbre_d && (irq_q || set_evt);
    end

    assign tbre = tbre_q;
    assign irq  = irq_q;

    // R12
    irq_needs_tbre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> tbre_q);
    // R10
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_wr && rst_n) |-> !tbre_q);
    // R12
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ie && rst_n) |-> !irq_q);
endmodule

// File: rtl/sc_status_reg.sv
// Module: top of the smart card UART status register. Assembles the
// status byte from direct levels and the three flag submodules.
// Assumes all event inputs are synchronous one-cycle pulses.
module sc_status_reg #(
    parameter int RX_FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_ready,
    input  logic       rx_overrun,
    input  logic       rx_parity_err,
    input  logic       rx_nostop_err,
    input  logic       rx_silent,
    input  logic       fifo_push,
    input  logic       fifo_push_err,
    input  logic       fifo_pop,
    input  logic       fifo_pop_err,
    input  logic       fifo_mode,
    input  logic       tx_hold_load,
    input  logic       tx_fifo_empty,
    input  logic       tx_sr_empty,
    input  logic       host_wr_tx,
    input  logic       tbe_ie,
    input  logic       status_rd,
    output logic [7:0] status,
    output logic       irq
);
    import scsr_pkg::*;

    rx_evt_t               evt;
    logic [N_RX_EVT-1:0]   sticky;
    logic                  rxfe, tbre;

    assign evt = '{silent: rx_silent, nostop: rx_nostop_err,
                   parity: rx_parity_err, overrun: rx_overrun};

    scsr_sticky_flags #(.N(N_RX_EVT)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .rd    (status_rd),
        .flags (sticky)
    );

    scsr_rx_err_track #(.DEPTH(RX_FIFO_DEPTH)) u_rxerr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fifo_push),
        .push_err (fifo_push_err),
        .pop      (fifo_pop),
        .pop_err  (fifo_pop_err),
        .rd       (status_rd),
        .flag     (rxfe)
    );

    scsr_tx_empty u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_mode     (fifo_mode),
        .hold_load     (tx_hold_load),
        .tx_fifo_empty (tx_fifo_empty),
        .host_wr       (host_wr_tx),
        .ie            (tbe_ie),
        .tbre          (tbre),
        .irq           (irq)
    );

    // Assemble the status byte; bits 0 and 6 are live levels.
    assign status = {rxfe, tx_sr_empty, tbre, sticky, rx_ready};

    // R1
    reset_irq_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !irq);
endmodule

// File: tb/tb_sc_status_reg.sv
module tb_sc_status_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_ready = 0, rx_overrun = 0, rx_parity_err = 0, rx_nostop_err = 0, rx_silent = 0;
    logic fifo_push = 0, fifo_push_err = 0, fifo_pop = 0, fifo_pop_err = 0;
    logic fifo_mode = 0, tx_hold_load = 0, tx_fifo_empty = 1, tx_sr_empty = 1;
    logic host_wr_tx = 0, tbe_ie = 0, status_rd = 0;
    logic [7:0] status;
    logic irq;
    int n_chk = 0, n_bad = 0;
    logic q_err [$];   // model of the receive FIFO's error tags

    always #2.5 clk = ~clk;   // 200 MHz

    sc_status_reg dut (.*);

    initial begin
        #1ms;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete (actual hang, expected finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance one edge, then sample away from it.
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic push(logic e);
        fifo_push = 1; fifo_push_err = e; q_err.push_back(e);
        step(); fifo_push = 0; fifo_push_err = 0;
    endtask

    task automatic pop(logic rd);
        fifo_pop = 1; fifo_pop_err = q_err.pop_front(); status_rd = rd;
        step(); fifo_pop = 0; fifo_pop_err = 0; status_rd = 0;
    endtask

    task automatic rd_pulse();
        status_rd = 1; step(); status_rd = 0;
    endtask

    task automatic t_reset();
        chk("R1 status", status, 8'h60);
        chk("R1 irq", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_rx_ready();
        rx_ready = 1; #1; chk("R2 set", {7'd0, status[0]}, 8'd1);
        rx_ready = 0; #1; chk("R2 clr", {7'd0, status[0]}, 8'd0);
    endtask

    task automatic t_sticky();
        rx_parity_err = 1; step(); rx_parity_err = 0;
        chk("R3 parity", {4'd0, status[4:1]}, 8'b0010);
        rx_silent = 1; step(); rx_silent = 0;
        chk("R3 silent", {4'd0, status[4:1]}, 8'b1010);
        step(); chk("R3 hold", {4'd0, status[4:1]}, 8'b1010);
        rd_pulse(); chk("R3 read clr", {4'd0, status[4:1]}, 8'd0);
        rx_overrun = 1; rx_nostop_err = 1; status_rd = 1; step();
        rx_overrun = 0; rx_nostop_err = 0; status_rd = 0;
        chk("R3 evt+read", {4'd0, status[4:1]}, 8'b0101);
        rd_pulse(); chk("R3 clr2", {4'd0, status[4:1]}, 8'd0);
    endtask

    task automatic t_rxfe();
        push(1); chk("R4 set", {7'd0, status[7]}, 8'd1);
        push(0); push(1);
        pop(1); chk("R5 read keeps", {7'd0, status[7]}, 8'd1);
        pop(0); pop(0);
        chk("R6 drain no read", {7'd0, status[7]}, 8'd1);
        rd_pulse(); chk("R5 read clr", {7'd0, status[7]}, 8'd0);
        push(1); pop(1); chk("R5 pop+read clr", {7'd0, status[7]}, 8'd0);
    endtask

    task automatic t_tsre();
        tx_sr_empty = 0; #1; chk("R7 lo", {7'd0, status[6]}, 8'd0);
        tx_sr_empty = 1; #1; chk("R7 hi", {7'd0, status[6]}, 8'd1);
    endtask

    task automatic t_nonfifo();
        fifo_mode = 0; tbe_ie = 0;
        host_wr_tx = 1; tx_fifo_empty = 0; step(); host_wr_tx = 0;
        chk("R10 wr clr", {7'd0, status[5]}, 8'd0);
        tx_fifo_empty = 1; step(); step();
        chk("R8 fifo edge ignored", {7'd0, status[5]}, 8'd0);
        tx_hold_load = 1; step(); tx_hold_load = 0;
        chk("R8 load sets", {7'd0, status[5]}, 8'd1);
        chk("R11 no irq ie=0", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_fifo_mode();
        fifo_mode = 1; tbe_ie = 1;
        host_wr_tx = 1; tx_fifo_empty = 0; step(); host_wr_tx = 0;
        chk("R10 wr clr", {7'd0, status[5]}, 8'd0);
        tx_hold_load = 1; step(); tx_hold_load = 0;
        chk("R9 load ignored", {6'd0, status[5], irq}, 8'd0);
        tx_fifo_empty = 1; step();
        chk("R9 empty sets", {7'd0, status[5]}, 8'd1);
        chk("R11 irq", {7'd0, irq}, 8'd1);
        host_wr_tx = 1; tx_fifo_empty = 0; step(); host_wr_tx = 0;
        chk("R12 clr by wr", {6'd0, status[5], irq}, 8'd0);
        host_wr_tx = 1; tx_fifo_empty = 1; step(); host_wr_tx = 0;
        chk("R10 wr beats set", {6'd0, status[5], irq}, 8'd0);
        tx_fifo_empty = 0; step(); tx_fifo_empty = 1; step();
        chk("R11 irq again", {6'd0, status[5], irq}, 8'b11);
        tbe_ie = 0; step();
        chk("R12 ie off", {6'd0, status[5], irq}, 8'b10);
    endtask

    initial begin
        step(); step(); rst_n = 1; step();
        t_reset();
        t_rx_ready();
        t_sticky();
        t_rxfe();
        t_tsre();
        t_nonfifo();
        t_fifo_mode();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule